// File: doc/BRIEF.md
# Adaptive Equalizer Lock-Mode Controller

This block is the control state machine that sits beside an adaptive cable equalizer. It decides whether the equalization engine keeps adapting or has its settings frozen. It also decides when a fresh equalization run has to start. The analog equalizer, the cable-length estimation and the signal detector are outside the block. They appear only as the single-bit inputs `lock_i`, `sig_present_i` and `auto_pol_i`.

A 2-bit policy field from a configuration register selects one of four behaviours:

- **Continuous adaptation.** The engine never stays frozen.
- **Freeze until software restart.** The setting is held until software passes the field through the continuous code and back.
- **Freeze until long signal loss.** A dropout longer than a parameterized timeout re-arms adaptation when the signal returns.
- **Manual.** All automatic adjustment is off, and polarity comes only from the invert controls.

An external freeze pin overrides the register control. While the pin is high, the controller holds its whole state.

All outputs are registered. Inputs sampled at a rising clock edge are reflected on the outputs just after that same edge. The restart command `reeq_o` is a one-cycle pulse, and it is always accompanied by `adapt_o` high.

Top module: `eq_lock_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves `adapt_o`=1, `reeq_o`=0, `manual_o`=0, `pol_src_o`=0 and `pol_o`=0, whatever the policy field and lock input hold. No restart pulse follows reset release when the field is left unchanged.
- R2: With policy field `mode_i`=2'b00 (continuous) and `freeze_pin_i` low, `adapt_o` is 1 after the edge, even while `lock_i` is high.
- R3: With `mode_i`=2'b10 or 2'b01, the controller adapting and `lock_i` high at an edge, `adapt_o` becomes 0 after that edge.
- R4: With `mode_i`=2'b10 held, once frozen the controller stays frozen whatever `lock_i` and `sig_present_i` do.
- R5: When the accepted policy field changes from 2'b00 to 2'b10, `reeq_o` and `adapt_o` are both 1 after that edge. A change from 2'b01 or 2'b11 to 2'b10 gives no pulse, and a move between 2'b10 and 2'b01 keeps an existing freeze.
- R6: With `mode_i`=2'b01 and frozen, a run of fewer than LOSS_CYC consecutive edges with `sig_present_i` low leaves `adapt_o`=0 and gives no pulse.
- R7: With `mode_i`=2'b01 and frozen, after at least LOSS_CYC consecutive edges with `sig_present_i` low, the first edge with the signal back gives `reeq_o`=1 and `adapt_o`=1. The output stays frozen until then.
- R8: With `mode_i`=2'b11, `manual_o`=1, `pol_src_o`=1, `adapt_o`=0, and `pol_o` equals `inv_pin_i | inv_reg_i` regardless of `auto_pol_i`.
- R9: In the three automatic policies, `pol_src_o`=0 and `pol_o` equals `auto_pol_i ^ (inv_pin_i | inv_reg_i)`.
- R10: Changing `inv_pin_i` or `inv_reg_i` never produces `reeq_o` and never changes `adapt_o`.
- R11: While `freeze_pin_i` is high, `adapt_o`=0 and `reeq_o`=0, and policy changes and lock events are ignored. On release, the field is compared with the last field accepted before the pin rose.
- R12: `reeq_o` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Policy field: 00 continuous, 10 freeze until restart, 01 freeze until long loss, 11 manual |
| lock_i | input | 1 | Engine reports it has converged |
| sig_present_i | input | 1 | Signal detector output |
| freeze_pin_i | input | 1 | External hold pin; must be low for register control |
| inv_pin_i | input | 1 | Polarity invert, hardware pin |
| inv_reg_i | input | 1 | Polarity invert, register bit |
| auto_pol_i | input | 1 | Polarity chosen by the automatic correction |
| adapt_o | output | 1 | 1 = engine adapts, 0 = settings frozen |
| reeq_o | output | 1 | One-cycle restart-equalization pulse |
| manual_o | output | 1 | Automatic adjustments disabled |
| pol_src_o | output | 1 | 1 = polarity from invert controls only |
| pol_o | output | 1 | Resolved polarity select |

## Verification
The assertions assume that every input is synchronous to `clk` and is held stable across each rising edge. They also assume that a reset lasts at least one edge. The stimulus changes inputs only on falling edges and holds reset high through whole cycles. The bench uses a small LOSS_CYC so that dropouts just under and at the timeout can both be reached within a short run.

// File: rtl/eq_lock_pkg.sv
package eq_lock_pkg;

  typedef enum logic [1:0] {
    MODE_CONT    = 2'b00,
    MODE_SIGLOSS = 2'b01,
    MODE_RSTLOCK = 2'b10,
    MODE_MANUAL  = 2'b11
  } eq_mode_e;

  typedef enum logic [1:0] {
    ST_ADAPT   = 2'b00,
    ST_LOCKED  = 2'b01,
    ST_EXPIRED = 2'b10,
    ST_MANUAL  = 2'b11
  } lk_state_e;

endpackage

// File: rtl/eq_loss_timer.sv
module eq_loss_timer #(
  parameter int LOSS_CYC = 200_000,
  localparam int CW = $clog2(LOSS_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic run_i,
  output logic near_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (hold_i)  cnt_q <= cnt_q;
    else if (run_i)   cnt_q <= cnt_q + CW'(1);
    else              cnt_q <= '0;
  end

  assign near_o = (cnt_q == CW'(LOSS_CYC - 1));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(LOSS_CYC)) else $error("loss counter overran"); // R7

  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!rst && !hold_i && !run_i) |=> (cnt_q == '0)) else $error("counter not cleared"); // R6

endmodule

// File: rtl/eq_lock_fsm.sv
module eq_lock_fsm
  import eq_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      frz_i,
  input  logic [1:0] mode_i,
  input  logic      lock_i,
  input  logic      sig_i,
  input  logic      near_i,
  output lk_state_e nstate_o,
  output logic      reeq_n_o,
  output logic      run_o
);

  lk_state_e state_q;
  eq_mode_e  eff_q;
  eq_mode_e  mode;

  assign mode = eq_mode_e'(mode_i);

  always_comb begin
    nstate_o = state_q;
    reeq_n_o = 1'b0;
    if (!frz_i) begin
      unique case (mode)
        MODE_CONT:   nstate_o = ST_ADAPT;
        MODE_MANUAL: nstate_o = ST_MANUAL;
        MODE_RSTLOCK: begin
          if (eff_q == MODE_CONT) begin
            nstate_o = ST_ADAPT;
            reeq_n_o = 1'b1;
          end else begin
            case (state_q)
              ST_MANUAL:             nstate_o = ST_ADAPT;
              ST_LOCKED, ST_EXPIRED: nstate_o = ST_LOCKED;
              default:               nstate_o = lock_i ? ST_LOCKED : ST_ADAPT;
            endcase
          end
        end
        MODE_SIGLOSS: begin
          case (state_q)
            ST_MANUAL: nstate_o = ST_ADAPT;
            ST_ADAPT:  nstate_o = lock_i ? ST_LOCKED : ST_ADAPT;
            ST_LOCKED: nstate_o = (!sig_i && near_i) ? ST_EXPIRED : ST_LOCKED;
            default: begin
              if (sig_i) begin
                nstate_o = ST_ADAPT;
                reeq_n_o = 1'b1;
              end
            end
          endcase
        end
      endcase
    end
  end

  assign run_o = !frz_i && (mode == MODE_SIGLOSS) && (state_q == ST_LOCKED) && !sig_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ADAPT;
      eff_q   <= mode;
    end else begin
      state_q <= nstate_o;
      if (!frz_i) eff_q <= mode;
    end
  end

  AST_LUR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && !frz_i && state_q == ST_LOCKED && mode == MODE_RSTLOCK && eff_q == MODE_RSTLOCK)
    |=> (state_q == ST_LOCKED)) else $error("freeze released in restart-lock policy"); // R4

  AST_EXPIRED_WAIT: assert property (@(posedge clk) disable iff (rst)
    (!rst && !frz_i && state_q == ST_EXPIRED && mode == MODE_SIGLOSS && !sig_i)
    |=> (state_q == ST_EXPIRED)) else $error("left expired state without signal"); // R7

  AST_FRZ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rst && frz_i) |=> (state_q == $past(state_q))) else $error("state moved under freeze pin"); // R11

endmodule

// File: rtl/eq_out_stage.sv
module eq_out_stage
  import eq_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lk_state_e nstate_i,
  input  logic      reeq_n_i,
  input  logic      frz_i,
  input  logic      inv_i,
  input  logic      auto_pol_i,
  output logic      adapt_o,
  output logic      reeq_o,
  output logic      manual_o,
  output logic      pol_src_o,
  output logic      pol_o
);

  logic is_man;
  assign is_man = (nstate_i == ST_MANUAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      adapt_o   <= 1'b1;
      reeq_o    <= 1'b0;
      manual_o  <= 1'b0;
      pol_src_o <= 1'b0;
      pol_o     <= 1'b0;
    end else begin
      adapt_o   <= !frz_i && (nstate_i == ST_ADAPT);
      reeq_o    <= !frz_i && reeq_n_i;
      manual_o  <= is_man;
      pol_src_o <= is_man;
      pol_o     <= is_man ? inv_i : (auto_pol_i ^ inv_i);
    end
  end

  AST_REEQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    reeq_o |=> !reeq_o) else $error("restart pulse wider than one cycle"); // R12

  AST_REEQ_ADAPT: assert property (@(posedge clk) disable iff (rst)
    reeq_o |-> adapt_o) else $error("restart without adapt"); // R5

  AST_FRZ_OUT: assert property (@(posedge clk) disable iff (rst)
    (!rst && frz_i) |=> (!adapt_o && !reeq_o)) else $error("freeze pin not obeyed"); // R11

endmodule

// File: rtl/eq_lock_ctrl.sv
module eq_lock_ctrl #(
  parameter int LOSS_CYC = 200_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       lock_i,
  input  logic       sig_present_i,
  input  logic       freeze_pin_i,
  input  logic       inv_pin_i,
  input  logic       inv_reg_i,
  input  logic       auto_pol_i,
  output logic       adapt_o,
  output logic       reeq_o,
  output logic       manual_o,
  output logic       pol_src_o,
  output logic       pol_o
);
  import eq_lock_pkg::*;

  lk_state_e nstate;
  logic      reeq_n;
  logic      run;
  logic      near;
  logic      inv_any;

  assign inv_any = inv_pin_i | inv_reg_i;

  eq_loss_timer #(.LOSS_CYC(LOSS_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .hold_i (freeze_pin_i),
    .run_i  (run),
    .near_o (near)
  );

  eq_lock_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .frz_i    (freeze_pin_i),
    .mode_i   (mode_i),
    .lock_i   (lock_i),
    .sig_i    (sig_present_i),
    .near_i   (near),
    .nstate_o (nstate),
    .reeq_n_o (reeq_n),
    .run_o    (run)
  );

  eq_out_stage u_out (
    .clk        (clk),
    .rst        (rst),
    .nstate_i   (nstate),
    .reeq_n_i   (reeq_n),
    .frz_i      (freeze_pin_i),
    .inv_i      (inv_any),
    .auto_pol_i (auto_pol_i),
    .adapt_o    (adapt_o),
    .reeq_o     (reeq_o),
    .manual_o   (manual_o),
    .pol_src_o  (pol_src_o),
    .pol_o      (pol_o)
  );

  AST_CONT_ADAPT: assert property (@(posedge clk) disable iff (rst)
    (!rst && !freeze_pin_i && mode_i == 2'b00) |=> adapt_o) else $error("continuous policy froze"); // R2

  AST_MAN_POL: assert property (@(posedge clk) disable iff (rst)
    (!rst && !freeze_pin_i && mode_i == 2'b11)
    |=> (manual_o && pol_src_o && !adapt_o && pol_o == $past(inv_any))) else $error("manual outputs wrong"); // R8

  AST_AUTO_POL: assert property (@(posedge clk) disable iff (rst)
    (!rst && !freeze_pin_i && mode_i != 2'b11)
    |=> (!pol_src_o && pol_o == ($past(auto_pol_i) ^ $past(inv_any)))) else $error("auto polarity wrong"); // R9

endmodule

// File: tb/eq_lock_ctrl_bench.sv
`timescale 1ns/1ps
module eq_lock_ctrl_bench;

  localparam int LOSS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic lock = 1'b0, sig = 1'b1, frz = 1'b0;
  logic invp = 1'b0, invr = 1'b0, apol = 1'b0;
  logic adapt, reeq, man, psrc, pol;

  always #2.5 clk = ~clk;

  eq_lock_ctrl #(.LOSS_CYC(LOSS)) u_eq_lock_ctrl (
    .clk(clk), .rst(rst), .mode_i(mode), .lock_i(lock), .sig_present_i(sig),
    .freeze_pin_i(frz), .inv_pin_i(invp), .inv_reg_i(invr), .auto_pol_i(apol),
    .adapt_o(adapt), .reeq_o(reeq), .manual_o(man), .pol_src_o(psrc), .pol_o(pol)
  );

  typedef struct {
    logic [4:0] val;
    logic [4:0] msk;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Expected order of the vector: {adapt, reeq, manual, pol_src, pol}
  localparam logic [4:0] M_AR  = 5'b11000;
  localparam logic [4:0] M_ALL = 5'b11111;
  localparam logic [4:0] M_P   = 5'b00011;

  task automatic tick(input logic [4:0] v, input logic [4:0] m, input string tag);
    exp_t e;
    e.val = v; e.msk = m; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: pops one expectation per edge and compares.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        logic [4:0] act;
        e = sb.pop_front();
        act = {adapt, reeq, man, psrc, pol};
        if (e.msk != '0) begin
          checks++;
          if ((act & e.msk) !== (e.val & e.msk)) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b mask=%b", e.tag, act, e.val, e.msk);
          end
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset with manual code and lock asserted
    mode = 2'b11; lock = 1'b1; rst = 1'b1;
    tick(5'b00000, 5'b00000, "R1");
    tick(5'b10000, M_ALL, "R1 reset state");
    rst = 1'b0;

    // R2: continuous ignores lock
    mode = 2'b00;
    tick(5'b10000, M_AR, "R2 cont lock high");
    tick(5'b10000, M_AR, "R2 cont stays");
    apol = 1'b1;
    tick(5'b10001, M_ALL, "R9 auto pol");
    invp = 1'b1;
    tick(5'b10000, M_ALL, "R9 auto pol inverted");
    invp = 1'b0; apol = 1'b0;
    tick(5'b10000, M_AR, "R2");

    // R5: 00 -> 10 restart pulse, then R3 lock
    mode = 2'b10;
    tick(5'b11000, M_AR, "R5 restart pulse");
    tick(5'b00000, M_AR, "R3 R12 freeze on lock");

    // R4: hold regardless of lock and signal
    lock = 1'b0; sig = 1'b0;
    for (int i = 0; i < 3; i++) tick(5'b00000, M_AR, "R4 held");
    invr = 1'b1; tick(5'b00000, M_AR, "R10 inv toggle");
    invr = 1'b0; tick(5'b00000, M_AR, "R10 inv toggle");
    invp = 1'b1; tick(5'b00000, M_AR, "R10 inv toggle");
    invp = 1'b0; sig = 1'b1;
    tick(5'b00000, M_AR, "R4 held");

    // R5: moves between 10 and 01 keep freeze, no pulse
    mode = 2'b01; tick(5'b00000, M_AR, "R5 10->01 keep");
    mode = 2'b10; tick(5'b00000, M_AR, "R5 01->10 no pulse");

    // R5: software restart sequence
    mode = 2'b00; tick(5'b10000, M_AR, "R5 via cont");
    mode = 2'b10; tick(5'b11000, M_AR, "R5 restart");
    tick(5'b10000, M_AR, "R12 pulse one cycle");
    lock = 1'b1; tick(5'b00000, M_AR, "R3 relock");

    // R6: short dropout in 01
    mode = 2'b01; lock = 1'b0;
    tick(5'b00000, M_AR, "R6 locked");
    sig = 1'b0;
    for (int i = 0; i < LOSS - 1; i++) tick(5'b00000, M_AR, "R6 short drop");
    sig = 1'b1;
    tick(5'b00000, M_AR, "R6 no restart");
    tick(5'b00000, M_AR, "R6 no restart");

    // R7: long dropout
    sig = 1'b0;
    for (int i = 0; i < LOSS + 3; i++) tick(5'b00000, M_AR, "R7 long drop");
    sig = 1'b1;
    tick(5'b11000, M_AR, "R7 restart on return");
    tick(5'b10000, M_AR, "R12 after loss restart");
    lock = 1'b1; tick(5'b00000, M_AR, "R3 siglose relock");
    lock = 1'b0;

    // R8: manual
    mode = 2'b11; invr = 1'b1;
    tick(5'b00111, M_ALL, "R8 manual inv");
    invr = 1'b0; tick(5'b00110, M_ALL, "R8 manual noinv R10");
    apol = 1'b1; tick(5'b00110, M_ALL, "R8 auto ignored");
    invp = 1'b1; tick(5'b00111, M_ALL, "R8 pin inv");
    invp = 1'b0; apol = 1'b0;

    // R11: freeze pin
    mode = 2'b00; tick(5'b10000, M_AR, "R2 from manual");
    frz = 1'b1; tick(5'b00000, M_AR, "R11 pin high");
    mode = 2'b10; tick(5'b00000, M_AR, "R11 mode change held");
    lock = 1'b1; tick(5'b00000, M_AR, "R11 lock ignored");
    frz = 1'b0; lock = 1'b0;
    tick(5'b11000, M_AR, "R11 release compares last field");
    tick(5'b10000, M_AR, "R12");

    // R1: reset while frozen, no pulse after release
    lock = 1'b1; tick(5'b00000, M_AR, "R3");
    rst = 1'b1; tick(5'b10000, M_ALL, "R1 reset from frozen");
    rst = 1'b0; lock = 1'b0;
    tick(5'b10000, M_AR, "R1 no pulse after reset");
    tick(5'b10000, M_AR, "R1");

    tick(5'b00000, 5'b00000, "drain");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule